// File: doc/BRIEF.md
# Flag-Driven Crystal Record Zero Suppressor

This block thins out the per-crystal data of an event before it moves on. Each input record holds the ten 16-bit time samples of one crystal. It also carries the crystal's identifier and the index of the 25-crystal readout tower the crystal belongs to. A small table, written from outside, holds a 2-bit readout mode for every tower. That mode comes from a high/medium/low interest classification made elsewhere, and it decides what happens to every crystal of the tower. The crystal can be discarded outright, passed on unconditionally, or passed on only if a weighted sum of its samples clears a threshold.

The weighted sum is a ten-tap filter. Each sample is multiplied by its own signed 12-bit weight, and the ten products are added in a 32-bit signed accumulator. The record survives only when the sum is strictly above a signed threshold. Weights and threshold are quasi-static configuration inputs. The block accepts one record per cycle with no stalls. Surviving records leave two clock edges after they enter, unchanged and in arrival order. A discarded record costs only the cycle in which it was presented. The unused mode code passes records through like full readout and raises an error flag alongside the record.

Top module: `sr_zero_suppress`

## Requirements
- R1: After a synchronous reset, `out_valid` and `out_err` are low.
- R2: A record whose tower mode is 00 (no readout) produces no output.
- R3: A record whose tower mode is 10 (full readout) is always forwarded, whatever its samples.
- R4: A record whose tower mode is 01 (suppressed readout) is forwarded only when its filter sum is strictly greater than `thresh`. A sum equal to `thresh` drops the record.
- R5: The filter sum is the sum over i = 0..9 of the signed 12-bit weight at `coef_flat[i*12 +: 12]` times the unsigned sample at `in_samples[i*16 +: 16]`. Weights may be negative.
- R6: A record whose tower mode is 11 is forwarded as in full readout, and `out_err` is high in the same cycle as that output word. `out_err` is low for every other output.
- R7: A record sampled at clock edge k appears at edge k+2. Its tower index, crystal identifier and all samples are unchanged, and kept records stay in input order.
- R8: Records may be presented on every consecutive cycle. A run of kept records comes out on consecutive cycles, with no gaps between them.
- R9: A mode written into the table at one clock edge applies to records sampled from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input record present |
| in_tower | input | 6 | Readout tower index of the record |
| in_xtal | input | 12 | Crystal identifier |
| in_samples | input | 160 | Ten 16-bit samples, sample i at bits i*16 |
| coef_flat | input | 120 | Ten signed 12-bit weights, weight i at bits i*12 |
| thresh | input | 32 | Signed keep threshold |
| fw_en | input | 1 | Write enable for the mode table |
| fw_tower | input | 6 | Tower whose mode is written |
| fw_mode | input | 2 | Mode value: 00 none, 01 suppressed, 10 full, 11 invalid |
| out_valid | output | 1 | Output record present |
| out_tower | output | 6 | Tower index of the kept record |
| out_xtal | output | 12 | Crystal identifier of the kept record |
| out_samples | output | 160 | Samples of the kept record |
| out_err | output | 1 | Kept record came from a tower with mode 11 |

## Verification
The bench uses the default parameters: 64 towers, ten taps of 16-bit samples, 12-bit weights and a 32-bit accumulator. With 64 towers, a single table fill covers every mode, and each mode shows up on 16 towers. Weights can reach the full 12-bit signed range, so sums built around a fixed threshold can land exactly on it, one above it, or far below it with negative weights. Tap ordering is checked by setting a single non-zero weight, so a sample in the wrong lane changes the keep decision.

// File: rtl/srzs_pkg.sv
package srzs_pkg;
  typedef enum logic [1:0] {
    RO_SKIP = 2'b00,
    RO_ZS   = 2'b01,
    RO_FULL = 2'b10,
    RO_BAD  = 2'b11
  } ro_mode_t;
endpackage

// File: rtl/srzs_flag_ram.sv
module srzs_flag_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/srzs_fir.sv
module srzs_fir #(
  parameter int TAPS = 10,
  parameter int SW   = 16,
  parameter int CW   = 12,
  parameter int ACCW = 32,
  localparam int PW  = CW + SW + 1
) (
  input  logic [TAPS*SW-1:0]     samples,
  input  logic [TAPS*CW-1:0]     coefs,
  output logic signed [ACCW-1:0] sum
);
  logic signed [PW-1:0] prod [TAPS];

  // one multiplier per tap; sample taken as unsigned
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign prod[g] = $signed(coefs[g*CW +: CW]) * $signed({1'b0, samples[g*SW +: SW]});
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) sum = sum + ACCW'(prod[i]);
  end
endmodule

// File: rtl/sr_zero_suppress.sv
module sr_zero_suppress
  import srzs_pkg::*;
#(
  parameter int N_TAPS   = 10,
  parameter int SAMP_W   = 16,
  parameter int COEF_W   = 12,
  parameter int ACC_W    = 32,
  parameter int N_TOWERS = 64,
  parameter int XTAL_W   = 12,
  localparam int TOW_W   = $clog2(N_TOWERS),
  localparam int REC_W   = N_TAPS * SAMP_W,
  localparam int CFG_W   = N_TAPS * COEF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [TOW_W-1:0]        in_tower,
  input  logic [XTAL_W-1:0]       in_xtal,
  input  logic [REC_W-1:0]        in_samples,
  input  logic [CFG_W-1:0]        coef_flat,
  input  logic signed [ACC_W-1:0] thresh,
  input  logic                    fw_en,
  input  logic [TOW_W-1:0]        fw_tower,
  input  logic [1:0]              fw_mode,
  output logic                    out_valid,
  output logic [TOW_W-1:0]        out_tower,
  output logic [XTAL_W-1:0]       out_xtal,
  output logic [REC_W-1:0]        out_samples,
  output logic                    out_err
);
  // stage 1: registered record and mode lookup
  logic                    s1_valid;
  logic [TOW_W-1:0]        s1_tower;
  logic [XTAL_W-1:0]       s1_xtal;
  logic [REC_W-1:0]        s1_samples;
  logic [1:0]              mode_raw;
  ro_mode_t                s1_mode;
  logic signed [ACC_W-1:0] fir_sum;
  logic                    keep;

  srzs_flag_ram #(.DEPTH(N_TOWERS), .DW(2)) u_modes (
    .clk   (clk),
    .we    (fw_en),
    .waddr (fw_tower),
    .wdata (fw_mode),
    .raddr (in_tower),
    .rdata (mode_raw)
  );

  assign s1_mode = ro_mode_t'(mode_raw);

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    if (in_valid) begin
      s1_tower   <= in_tower;
      s1_xtal    <= in_xtal;
      s1_samples <= in_samples;
    end
  end

  srzs_fir #(.TAPS(N_TAPS), .SW(SAMP_W), .CW(COEF_W), .ACCW(ACC_W)) u_fir (
    .samples (s1_samples),
    .coefs   (coef_flat),
    .sum     (fir_sum)
  );

  always_comb begin
    unique case (s1_mode)
      RO_SKIP: keep = 1'b0;
      RO_ZS:   keep = fir_sum > thresh;
      default: keep = 1'b1;
    endcase
  end

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s1_valid && keep;
      out_err   <= s1_valid && (s1_mode == RO_BAD);
    end
    if (s1_valid) begin
      out_tower   <= s1_tower;
      out_xtal    <= s1_xtal;
      out_samples <= s1_samples;
    end
  end

  // R7
  fwd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  // R7
  xtal_intact_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_xtal == $past(in_xtal, 2));
  // R2
  skip_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == RO_SKIP) |=> !out_valid);
  // R3
  full_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == RO_FULL) |=> out_valid);
  // R4
  zs_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == RO_ZS) |=> out_valid == $past(fir_sum > thresh));
  // R6
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid);
endmodule

// File: tb/sim_sr_zero_suppress.sv
module sim_sr_zero_suppress;
  localparam int TAPS = 10, SW = 16, CW = 12, AW = 32, NT = 64, XW = 12, TW = 6;
  localparam int EW = 1 + TW + XW + TAPS*SW;

  logic clk = 0, rst = 1;
  logic in_valid = 0;
  logic [TW-1:0] in_tower = '0;
  logic [XW-1:0] in_xtal = '0;
  logic [TAPS*SW-1:0] in_samples = '0;
  logic [TAPS*CW-1:0] coef_flat = '0;
  logic signed [AW-1:0] thresh = '0;
  logic fw_en = 0;
  logic [TW-1:0] fw_tower = '0;
  logic [1:0] fw_mode = '0;
  logic out_valid, out_err;
  logic [TW-1:0] out_tower;
  logic [XW-1:0] out_xtal;
  logic [TAPS*SW-1:0] out_samples;

  sr_zero_suppress u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int coefs [TAPS];
  logic [1:0] modem [NT];
  logic [EW-1:0] sb [$];
  int run = 0, max_run = 0, n_out = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop and compare each produced word
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [EW-1:0] got;
      got = {out_err, out_tower, out_xtal, out_samples};
      n_out++;
      run++;
      if (run > max_run) max_run = run;
      if (sb.size() == 0) chk(0, "R2 unexpected output xtal", longint'(out_xtal), -1);
      else begin
        logic [EW-1:0] e;
        e = sb.pop_front();
        chk(got == e, "R7 record/order", longint'(out_xtal), longint'(e[TAPS*SW +: XW]));
        chk(got[EW-1] == e[EW-1], "R6 err flag", longint'(got[EW-1]), longint'(e[EW-1]));
      end
    end else run = 0;
  end

  task automatic set_coefs(input int c [TAPS], input int th);
    for (int i = 0; i < TAPS; i++) begin
      coefs[i] = c[i];
      coef_flat[i*CW +: CW] = c[i][CW-1:0];
    end
    thresh = th;
    @(negedge clk);
  endtask

  task automatic write_mode(input int t, input logic [1:0] m);
    fw_en = 1; fw_tower = t[TW-1:0]; fw_mode = m; modem[t] = m;
    @(negedge clk);
    fw_en = 0;
  endtask

  // driver: present one record and push its expected result
  task automatic send(input int t, input int x, input logic [TAPS*SW-1:0] s);
    longint acc = 0;
    bit keep;
    for (int i = 0; i < TAPS; i++) acc += longint'(coefs[i]) * longint'(s[i*SW +: SW]);
    case (modem[t])
      2'b00: keep = 0;
      2'b01: keep = acc > longint'(thresh);
      default: keep = 1;
    endcase
    if (keep) sb.push_back({modem[t] == 2'b11, t[TW-1:0], x[XW-1:0], s});
    in_valid = 1; in_tower = t[TW-1:0]; in_xtal = x[XW-1:0]; in_samples = s;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [TAPS*SW-1:0] flat(input int v);
    logic [TAPS*SW-1:0] r;
    for (int i = 0; i < TAPS; i++) r[i*SW +: SW] = v[SW-1:0];
    return r;
  endfunction

  task automatic drain(input string req, input int exp_n, input int base);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0 && n_out - base == exp_n, req, longint'(n_out - base), longint'(exp_n));
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c [TAPS];
    int base;
    logic [TAPS*SW-1:0] s;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(out_valid == 0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(out_err == 0, "R1 out_err after reset", longint'(out_err), 0);
    // tower t gets mode t[1:0]: 0 skip, 1 suppressed, 2 full, 3 invalid
    for (int t = 0; t < NT; t++) write_mode(t, t[1:0]);
    foreach (c[i]) c[i] = 1;
    set_coefs(c, 100);

    // R2: skip towers drop even large records
    base = n_out;
    send(0, 1, flat(4000)); send(4, 2, flat(9)); send(60, 3, flat(65535));
    drain("R2 skip count", 0, base);
    // R3: full read forwards zero records
    base = n_out;
    send(2, 10, flat(0)); send(6, 11, flat(1));
    drain("R3 full count", 2, base);
    // R4: sum 100 equals threshold -> dropped, 101 -> kept
    base = n_out;
    send(1, 20, flat(10));
    s = flat(10); s[15:0] = 16'd11;
    send(5, 21, s);
    drain("R4 threshold boundary", 1, base);
    // R6: invalid code forwarded with error flag
    base = n_out;
    send(3, 30, flat(0));
    drain("R6 invalid code forwarded", 1, base);

    // R5: lane ordering with a single active tap 7
    foreach (c[i]) c[i] = 0;
    c[7] = 1;
    set_coefs(c, 49);
    base = n_out;
    s = '0; s[7*SW +: SW] = 16'd50; send(1, 40, s);
    s = '0; s[6*SW +: SW] = 16'd1000; send(1, 41, s);
    s = '0; s[8*SW +: SW] = 16'd1000; send(1, 42, s);
    drain("R5 tap lane", 1, base);
    // R5: negative weights, negative threshold
    foreach (c[i]) c[i] = (i % 2) ? -2048 : 3;
    set_coefs(c, -5);
    base = n_out;
    send(1, 50, flat(1));     // 5*3 - 5*2048 < -5 -> dropped
    s = '0; s[0 +: SW] = 16'd1; send(1, 51, s);   // 3 > -5 kept
    s = '0; s[SW +: SW] = 16'd0; send(1, 52, s);  // 0 > -5 kept
    drain("R5 negative weights", 2, base);

    // R9: rewrite tower 0 to full, record on next cycle kept
    base = n_out;
    write_mode(0, 2'b10);
    send(0, 60, flat(7));
    write_mode(2, 2'b00);
    send(2, 61, flat(7));
    drain("R9 mode rewrite", 1, base);

    // R8: burst of back-to-back full-read records
    foreach (c[i]) c[i] = 1;
    set_coefs(c, 200);
    base = n_out;
    max_run = 0;
    for (int k = 0; k < 16; k++) send(6 + 4 * (k % 8), 100 + k, flat(k * 3));
    drain("R8 burst count", 16, base);
    chk(max_run >= 16, "R8 no gaps", longint'(max_run), 16);

    // mixed random stream, R4/R7 against the scoreboard
    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < TAPS; i++) s[i*SW +: SW] = 16'($urandom_range(0, 40));
      send($urandom_range(0, NT - 1), 200 + k, s);
    end
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7 random stream drained", longint'(sb.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule